// File: doc/BRIEF.md
# Power-On Wakeup Qualification Sequencer

This block decides when a chip that has just powered up, or that sits in low-power standby, may be moved to run mode. It runs mainly from a 32.768 kHz slow clock. A divider turns that clock into a one-second tick. On each tick the block latches two status inputs: the battery-good level and the external-power-present level. After power-on reset is released, the block waits out a hold-off of whole seconds. Only then does it listen for a wakeup edge. A qualified wakeup with a good supply latched starts the bring-up. The block waits for the fast oscillator to report stable. It then times the PLL lock interval on the fast clock and raises the run request.

The two clock domains exchange only two single-bit levels, each through a two-flop synchronizer. The run go level travels from the slow domain to the fast domain, and the lock-ready level travels back. A user reset is accepted only when it stays low for a minimum number of slow-clock periods. An accepted user reset returns the sequencer to standby. The divider ratio, hold-off length, power-on gap, user reset minimum width and PLL wait length are all parameters, so a bench can shorten the long intervals.

The sequencer has six states, with these transitions:
- POR_HOLD, after power-on release, lasts `POR_GAP` slow cycles and then goes to HOLDOFF.
- HOLDOFF goes to STANDBY after `HOLDOFF_SEC` ticks.
- STANDBY goes to OSC_WAIT on a wakeup edge if a good supply is latched.
- OSC_WAIT goes to PLL_WAIT once the oscillator is stable.
- PLL_WAIT goes to RUN when the synchronized ready level is seen.
- RUN remains until a reset.

An accepted user reset takes STANDBY, OSC_WAIT, PLL_WAIT or RUN back to STANDBY.

Top module: `wake_qual_seq`

## Requirements
- R1: While `por_n` is low, and directly after it rises, `run_req`, `pll_ready`, `bat_lat` and `pwr_lat` are 0.
- R2: `bat_lat` and `pwr_lat` take the synchronized `bat_good` and `ext_pwr` levels only on the one-second tick. The tick occurs once every `SEC_DIV` slow cycles, counted from power-on release. Before the first tick, both latches stay 0.
- R3: A wakeup edge is ignored if it occurs within `HOLDOFF_SEC` ticks of power-on release, which includes the first `POR_GAP` slow cycles. A pulse whose both edges fall in that window never leads to run.
- R4: Both a rising and a falling wakeup edge qualify once hold-off has ended. A level held high across hold-off therefore qualifies on its later falling edge.
- R5: If neither `bat_lat` nor `pwr_lat` is 1 when a wakeup edge is seen in standby, the edge is ignored and `run_req` stays 0.
- R6: `pll_ready` rises only after at least `PLL_CYC` consecutive fast cycles in which both the synchronized go level and `osc_stable` are high. It returns to 0 after either one drops.
- R7: After a qualified wakeup, `run_req` rises only once `osc_stable` is high and `pll_ready` has crossed back to the slow domain. Without `osc_stable`, `run_req` and `pll_ready` stay 0.
- R8: A `usr_rst_n` low pulse of at least `RST_MIN` slow cycles makes the sequencer return to STANDBY from OSC_WAIT, PLL_WAIT or RUN, and `run_req` and `pll_ready` drop. A shorter pulse has no effect.
- R9: If an accepted user reset and a wakeup edge reach the sequencer in the same slow cycle while it is in STANDBY, the reset wins and that edge is used up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | 32.768 kHz slow clock |
| clk_fast | input | 1 | Fast oscillator clock used to time PLL lock |
| por_n | input | 1 | Active-low power-on reset; asserts asynchronously and releases synchronously |
| usr_rst_n | input | 1 | Active-low user reset; its width is qualified |
| wake_in | input | 1 | Wakeup pin; either edge can qualify |
| bat_good | input | 1 | Battery-good level |
| ext_pwr | input | 1 | External-power-present level |
| osc_stable | input | 1 | Fast oscillator stable indication |
| run_req | output | 1 | Run-mode request; high in RUN |
| pll_ready | output | 1 | PLL lock wait complete (fast domain) |
| bat_lat | output | 1 | Battery-good level latched on the tick |
| pwr_lat | output | 1 | External-power level latched on the tick |

## Verification
An accepted user reset and a qualified wakeup edge can land in the same slow cycle. Both travel through two-flop synchronizers of equal depth. To provoke the clash, the bench drives `usr_rst_n` low for exactly four slow cycles while the sequencer is in standby. It raises `wake_in` at the start of the fourth cycle, so the reset qualification and the wakeup edge reach the state logic together. The result is judged at the ports. `run_req` must stay 0 while the wakeup is held high, and must rise only after the later falling edge.

// File: rtl/wqs_pkg.sv
package wqs_pkg;
    typedef enum logic [2:0] {
        ST_POR_HOLD = 3'd0,
        ST_HOLDOFF  = 3'd1,
        ST_STANDBY  = 3'd2,
        ST_OSC_WAIT = 3'd3,
        ST_PLL_WAIT = 3'd4,
        ST_RUN      = 3'd5
    } wqs_state_e;
endpackage

// File: rtl/wqs_sync2.sv
module wqs_sync2 #(
    parameter logic RV = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            meta <= RV;
            q    <= RV;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/wqs_rst_sync.sv
module wqs_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic srst
);
    logic [1:0] pipe;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) pipe <= 2'b00;
        else         pipe <= {pipe[0], 1'b1};
    end

    assign srst = ~pipe[1];
endmodule

// File: rtl/wqs_tick_div.sv
module wqs_tick_div #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/wqs_pulse_qual.sv
module wqs_pulse_qual #(
    parameter int MIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic in_n,
    output logic fire
);
    localparam int CW = $clog2(MIN + 1);
    localparam logic [CW-1:0] TOP  = CW'(MIN);
    localparam logic [CW-1:0] EDGE = CW'(MIN - 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)               low_cnt <= '0;
        else if (in_n)         low_cnt <= '0;
        else if (low_cnt != TOP) low_cnt <= low_cnt + 1'b1;
    end

    assign fire = !in_n && (low_cnt == EDGE);
endmodule

// File: rtl/wqs_pll_timer.sv
module wqs_pll_timer #(
    parameter int CYC = 3687
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic osc_ok,
    output logic ready
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt;
    logic          en;

    assign en = go && osc_ok;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (!en) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (!ready) begin
            if (cnt == LAST) ready <= 1'b1;
            else             cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wake_qual_seq.sv
module wake_qual_seq
    import wqs_pkg::*;
#(
    parameter int SEC_DIV     = 32768,
    parameter int HOLDOFF_SEC = 2,
    parameter int POR_GAP     = 2,
    parameter int RST_MIN     = 4,
    parameter int PLL_CYC     = 3687
) (
    input  logic clk_slow,
    input  logic clk_fast,
    input  logic por_n,
    input  logic usr_rst_n,
    input  logic wake_in,
    input  logic bat_good,
    input  logic ext_pwr,
    input  logic osc_stable,
    output logic run_req,
    output logic pll_ready,
    output logic bat_lat,
    output logic pwr_lat
);
    localparam int MAXW = (HOLDOFF_SEC > POR_GAP) ? HOLDOFF_SEC : POR_GAP;
    localparam int WW   = $clog2(MAXW + 1);
    localparam logic [WW-1:0] GAP_LAST  = WW'(POR_GAP - 1);
    localparam logic [WW-1:0] HOLD_LAST = WW'(HOLDOFF_SEC - 1);

    logic       s_rst, f_rst;
    logic       tick, usr_s, usr_fire;
    logic       wk_s, wk_q, wk_edge;
    logic       bat_s, ext_s, osc_s, rdy_s;
    logic       go_q, go_f, osc_f;
    logic       active;
    logic [WW-1:0] wait_cnt;
    wqs_state_e st, st_nxt;

    wqs_rst_sync u_srst (.clk(clk_slow), .arst_n(por_n), .srst(s_rst));
    wqs_rst_sync u_frst (.clk(clk_fast), .arst_n(por_n), .srst(f_rst));

    wqs_tick_div #(.DIV(SEC_DIV)) u_div (.clk(clk_slow), .rst(s_rst), .tick(tick));

    wqs_sync2 #(.RV(1'b1)) u_usr (.clk(clk_slow), .rst(s_rst), .d(usr_rst_n),  .q(usr_s));
    wqs_sync2 u_wk  (.clk(clk_slow), .rst(s_rst), .d(wake_in),    .q(wk_s));
    wqs_sync2 u_bat (.clk(clk_slow), .rst(s_rst), .d(bat_good),   .q(bat_s));
    wqs_sync2 u_ext (.clk(clk_slow), .rst(s_rst), .d(ext_pwr),    .q(ext_s));
    wqs_sync2 u_osc (.clk(clk_slow), .rst(s_rst), .d(osc_stable), .q(osc_s));
    wqs_sync2 u_rdy (.clk(clk_slow), .rst(s_rst), .d(pll_ready),  .q(rdy_s));

    wqs_sync2 u_gof (.clk(clk_fast), .rst(f_rst), .d(go_q),       .q(go_f));
    wqs_sync2 u_osf (.clk(clk_fast), .rst(f_rst), .d(osc_stable), .q(osc_f));

    wqs_pulse_qual #(.MIN(RST_MIN)) u_uq (
        .clk(clk_slow), .rst(s_rst), .in_n(usr_s), .fire(usr_fire)
    );

    wqs_pll_timer #(.CYC(PLL_CYC)) u_pll (
        .clk(clk_fast), .rst(f_rst), .go(go_f), .osc_ok(osc_f), .ready(pll_ready)
    );

    // wakeup edge detector: previous level tracked every cycle, so edges
    // during POR_HOLD / HOLDOFF are simply discarded
    always_ff @(posedge clk_slow or posedge s_rst) begin
        if (s_rst) wk_q <= 1'b0;
        else       wk_q <= wk_s;
    end
    assign wk_edge = wk_s ^ wk_q;

    // supply status latched on the one-second tick only
    always_ff @(posedge clk_slow or posedge s_rst) begin
        if (s_rst) begin
            bat_lat <= 1'b0;
            pwr_lat <= 1'b0;
        end else if (tick) begin
            bat_lat <= bat_s;
            pwr_lat <= ext_s;
        end
    end

    assign active = (st != ST_POR_HOLD) && (st != ST_HOLDOFF);

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_POR_HOLD: if (wait_cnt == GAP_LAST)          st_nxt = ST_HOLDOFF;
            ST_HOLDOFF:  if (tick && wait_cnt == HOLD_LAST) st_nxt = ST_STANDBY;
            ST_STANDBY:  if (wk_edge && (bat_lat || pwr_lat)) st_nxt = ST_OSC_WAIT;
            ST_OSC_WAIT: if (osc_s)                         st_nxt = ST_PLL_WAIT;
            ST_PLL_WAIT: if (rdy_s)                         st_nxt = ST_RUN;
            ST_RUN:                                         st_nxt = ST_RUN;
            default:                                        st_nxt = ST_POR_HOLD;
        endcase
        if (usr_fire && active) st_nxt = ST_STANDBY;
    end

    // state register, interval counter and registered go level
    always_ff @(posedge clk_slow or posedge s_rst) begin
        if (s_rst) begin
            st       <= ST_POR_HOLD;
            wait_cnt <= '0;
            go_q     <= 1'b0;
        end else begin
            st   <= st_nxt;
            go_q <= (st_nxt == ST_PLL_WAIT) || (st_nxt == ST_RUN);
            if (st_nxt != st)
                wait_cnt <= '0;
            else if (st == ST_POR_HOLD || (st == ST_HOLDOFF && tick))
                wait_cnt <= wait_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        run_req = (st == ST_RUN);
    end
endmodule

// File: rtl/wqs_chk.sv
module wqs_chk
    import wqs_pkg::*;
#(
    parameter int HOLDOFF_SEC = 2,
    parameter int PLL_CYC     = 3687
) (
    input logic       clk_slow,
    input logic       clk_fast,
    input logic       s_rst,
    input logic       f_rst,
    input wqs_state_e st,
    input logic       tick,
    input logic       usr_fire,
    input logic       wk_edge,
    input logic       bat_lat,
    input logic       pwr_lat,
    input logic       rdy_s,
    input logic       run_req,
    input logic       pll_ready,
    input logic       go_f,
    input logic       osc_f
);
    localparam int TW = $clog2(HOLDOFF_SEC + 1);
    localparam int PW = $clog2(PLL_CYC + 1);

    logic [TW-1:0] ticks_seen;
    logic [PW-1:0] en_run;

    always_ff @(posedge clk_slow or posedge s_rst) begin
        if (s_rst) ticks_seen <= '0;
        else if (tick && ticks_seen != TW'(HOLDOFF_SEC)) ticks_seen <= ticks_seen + 1'b1;
    end

    always_ff @(posedge clk_fast or posedge f_rst) begin
        if (f_rst)               en_run <= '0;
        else if (!(go_f && osc_f)) en_run <= '0;
        else if (en_run != PW'(PLL_CYC)) en_run <= en_run + 1'b1;
    end

    // R2: latched supply status only moves right after a tick
    assert_lat_on_tick_R2: assert property (@(posedge clk_slow) disable iff (s_rst)
        (!$stable(bat_lat) || !$stable(pwr_lat)) |-> $past(tick));

    // R3: standby is reached only after the full hold-off of ticks
    assert_holdoff_done_R3: assert property (@(posedge clk_slow) disable iff (s_rst)
        (st == ST_STANDBY && $past(st) == ST_HOLDOFF) |-> (ticks_seen == TW'(HOLDOFF_SEC)));

    // R5: a wakeup edge without a good supply leaves standby in place
    assert_no_supply_R5: assert property (@(posedge clk_slow) disable iff (s_rst)
        (st == ST_STANDBY && wk_edge && !bat_lat && !pwr_lat && !usr_fire)
        |=> (st == ST_STANDBY));

    // R6: ready rises only after the full lock window
    assert_lock_window_R6: assert property (@(posedge clk_fast) disable iff (f_rst)
        $rose(pll_ready) |-> (en_run == PW'(PLL_CYC)));

    // R7: run request rises only with the crossed ready level
    assert_run_after_ready_R7: assert property (@(posedge clk_slow) disable iff (s_rst)
        $rose(run_req) |-> $past(rdy_s));

    // R8 / R9: accepted user reset forces standby next cycle
    assert_usr_reset_R8: assert property (@(posedge clk_slow) disable iff (s_rst)
        (usr_fire && st != ST_POR_HOLD && st != ST_HOLDOFF)
        |=> (st == ST_STANDBY && !run_req));
endmodule

bind wake_qual_seq wqs_chk #(.HOLDOFF_SEC(HOLDOFF_SEC), .PLL_CYC(PLL_CYC)) u_chk (
    .clk_slow (clk_slow),
    .clk_fast (clk_fast),
    .s_rst    (s_rst),
    .f_rst    (f_rst),
    .st       (st),
    .tick     (tick),
    .usr_fire (usr_fire),
    .wk_edge  (wk_edge),
    .bat_lat  (bat_lat),
    .pwr_lat  (pwr_lat),
    .rdy_s    (rdy_s),
    .run_req  (run_req),
    .pll_ready(pll_ready),
    .go_f     (go_f),
    .osc_f    (osc_f)
);

// File: tb/sim_wake_qual_seq.sv
module sim_wake_qual_seq;
    localparam int SEC_DIV     = 8;
    localparam int HOLDOFF_SEC = 2;
    localparam int POR_GAP     = 2;
    localparam int RST_MIN     = 4;
    localparam int PLL_CYC     = 20;

    // vector bits: [5] run expected, [4] osc_stable, [3:2] wake mode,
    // [1] ext_pwr, [0] bat_good
    // wake mode: 0 pulse after hold-off, 1 pulse inside hold-off only,
    //            2 high through hold-off, falls after it
    localparam int NV = 6;
    localparam logic [5:0] VEC [NV] = '{
        6'b1_1_10_0_1,
        6'b1_1_00_1_0,
        6'b0_1_00_0_0,
        6'b0_1_01_0_1,
        6'b0_0_00_0_1,
        6'b1_1_00_0_1
    };

    logic clk_fast = 1'b0;
    logic clk_slow = 1'b0;
    always #5  clk_fast = ~clk_fast;
    always #40 clk_slow = ~clk_slow;

    logic por_n = 1'b0, usr_rst_n = 1'b1, wake_in = 1'b0;
    logic bat_good = 1'b0, ext_pwr = 1'b0, osc_stable = 1'b0;
    logic run_req, pll_ready, bat_lat, pwr_lat;

    int total = 0;
    int bad   = 0;
    int lat   = 0;

    wake_qual_seq #(
        .SEC_DIV(SEC_DIV), .HOLDOFF_SEC(HOLDOFF_SEC), .POR_GAP(POR_GAP),
        .RST_MIN(RST_MIN), .PLL_CYC(PLL_CYC)
    ) u0 (
        .clk_slow(clk_slow), .clk_fast(clk_fast), .por_n(por_n),
        .usr_rst_n(usr_rst_n), .wake_in(wake_in), .bat_good(bat_good),
        .ext_pwr(ext_pwr), .osc_stable(osc_stable), .run_req(run_req),
        .pll_ready(pll_ready), .bat_lat(bat_lat), .pwr_lat(pwr_lat)
    );

    // fast cycles from osc_stable rising until pll_ready rises
    always @(posedge clk_fast) begin
        if (!osc_stable)     lat <= 0;
        else if (!pll_ready) lat <= lat + 1;
    end

    task automatic sc(input int n);
        repeat (n) @(negedge clk_slow);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_fast);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int v = 0; v < NV; v++) begin
            automatic logic [5:0] w = VEC[v];
            bat_good = w[0]; ext_pwr = w[1];
            wake_in = 1'b0; osc_stable = 1'b0; usr_rst_n = 1'b1;
            por_n = 1'b0;
            sc(3);
            if (v == 0) begin
                chk("R1 run_req in reset", int'(run_req), 0);
                chk("R1 pll_ready in reset", int'(pll_ready), 0);
                chk("R1 bat_lat in reset", int'(bat_lat), 0);
                chk("R1 pwr_lat in reset", int'(pwr_lat), 0);
            end
            por_n = 1'b1;
            sc(4);
            chk("R2 bat_lat before first tick", int'(bat_lat), 0);
            chk("R2 pwr_lat before first tick", int'(pwr_lat), 0);
            if (w[3:2] != 2'd0) wake_in = 1'b1;
            sc(3);
            if (w[3:2] == 2'd1) wake_in = 1'b0;
            sc(23);
            chk("R2 bat_lat after ticks", int'(bat_lat), int'(w[0]));
            chk("R2 pwr_lat after ticks", int'(pwr_lat), int'(w[1]));
            chk("R3 no run before late wakeup", int'(run_req), 0);
            if (w[3:2] == 2'd0) begin
                wake_in = 1'b1;
                sc(3);
                wake_in = 1'b0;
            end else if (w[3:2] == 2'd2) begin
                wake_in = 1'b0;
            end
            osc_stable = w[4];
            sc(12);
            chk($sformatf("R3/R4/R5/R7 vector %0d run_req", v), int'(run_req), int'(w[5]));
            chk($sformatf("R6/R7 vector %0d pll_ready", v), int'(pll_ready), int'(w[5]));
            if (w[5])
                chk($sformatf("R6 vector %0d lock latency in range", v),
                    int'(lat >= PLL_CYC && lat < PLL_CYC + 60), 1);
        end

        // R8: a 3-cycle user reset pulse is filtered out
        usr_rst_n = 1'b0; sc(RST_MIN - 1); usr_rst_n = 1'b1; sc(6);
        chk("R8 short user reset ignored", int'(run_req), 1);

        // R8: a 4-cycle pulse returns to standby and drops the lock
        usr_rst_n = 1'b0; sc(RST_MIN); usr_rst_n = 1'b1; sc(4);
        chk("R8 long user reset drops run", int'(run_req), 0);
        chk("R6 pll_ready drops with go", int'(pll_ready), 0);

        // R4: a fresh wakeup pulse brings it back
        wake_in = 1'b1; sc(3); wake_in = 1'b0; sc(12);
        chk("R4 wakeup after user reset", int'(run_req), 1);

        // move to standby again, then clash reset with a wakeup edge
        usr_rst_n = 1'b0; sc(RST_MIN); usr_rst_n = 1'b1; sc(4);
        chk("R8 back in standby", int'(run_req), 0);
        usr_rst_n = 1'b0; sc(RST_MIN - 1);
        wake_in = 1'b1; sc(1);
        usr_rst_n = 1'b1; sc(12);
        chk("R9 reset beats same-cycle wakeup edge", int'(run_req), 0);
        wake_in = 1'b0; sc(12);
        chk("R4 falling edge qualifies", int'(run_req), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule